// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the digital state machine that picks the operating mode of a LIN bus physical-layer interface. It samples five asynchronous flags:

- the enable pin;
- the transmit-data pin;
- a battery-supply-valid comparator;
- a regulator-undervoltage comparator;
- a bus wake-up detector.

From the current mode it drives four control outputs: a regulator enable, a transmit-path enable, a bus-termination enable and an active-low reset for the attached microcontroller.

The analog parts are modelled as plain input flags. These are the regulator, the comparators, the slope control and the receiver. The supply-valid flag is expected to carry the comparator's hysteresis: it rises above the upper threshold and falls below the lower one. A parameter gives the number of clock ticks per millisecond, so the reset hold-off scales down to a short window for simulation.

Every input passes through a synchronizer before the state register uses it. The mode that follows a falling edge on enable depends on the transmit pin at that moment. A transmit pin held high selects low-power listening. A transmit pin held low selects full sleep.

Top module: `lin_mode_ctrl`

## Requirements
- R1: Mode codes on `mode_o` are 0 = unpowered, 1 = fail-safe, 2 = normal, 3 = silent, 4 = sleep. With supply valid, the unpowered mode always moves to fail-safe, whatever the level of `en_i`.
- R2: A high `en_i` moves silent or sleep mode to normal. It also moves fail-safe to normal, but only while no undervoltage is flagged.
- R3: A falling edge of `en_i` in normal mode, with `txd_i` high, selects silent mode.
- R4: A falling edge of `en_i` in normal mode, with `txd_i` low, selects sleep mode.
- R5: A regulator undervoltage in normal or silent mode returns the block to fail-safe. In sleep mode the undervoltage flag has no effect on the mode.
- R6: Loss of the supply-valid flag returns the block to the unpowered mode from any mode.
- R7: In silent or sleep mode, with `en_i` low, a bus wake-up moves the block to fail-safe.
- R8: The output decode is as follows:
  - `reg_en_o` is low only in sleep and unpowered modes.
  - `tx_en_o` is high only in normal mode.
  - `term_en_o` is high only in normal and fail-safe modes.
- R9: `res_n_o` is low whenever an undervoltage is flagged or the mode is unpowered. Once the undervoltage clears, it stays low for HOLD_MS × TICKS_PER_MS further cycles.
- R10: Every input reaches the mode register through a two-flop synchronizer. A change of input shows on `mode_o` after the third rising clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable pin, asynchronous |
| txd_i | input | 1 | Transmit data pin, asynchronous, 0 = dominant |
| supply_ok_i | input | 1 | Battery supply valid flag (with hysteresis) |
| vcc_uv_i | input | 1 | Regulator output undervoltage flag |
| wake_i | input | 1 | Bus wake-up detected flag |
| mode_o | output | 3 | Current mode code (see R1) |
| reg_en_o | output | 1 | Regulator enable |
| tx_en_o | output | 1 | Transmit path enable |
| term_en_o | output | 1 | Bus termination enable |
| res_n_o | output | 1 | Active-low reset to the microcontroller |

## Verification
The assertions check the following on every cycle:
- each single-step mode transition taken from the synchronized flags, which covers power-up, supply loss, undervoltage fallback, and the silent or sleep choice on an enable fall;
- that a flagged undervoltage pulls reset low on the next cycle.

The bench scenarios are needed for the rest:
- the exact length of the reset hold-off after undervoltage clears;
- the three-edge input latency;
- that undervoltage is ignored in sleep mode;
- multi-step chains such as unpowered to fail-safe to normal under a constant input pattern.

Random sequences compare the mode and all control outputs against a reference model.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;
   typedef enum logic [2:0] {
      MODE_OFF    = 3'd0,
      MODE_SAFE   = 3'd1,
      MODE_NORMAL = 3'd2,
      MODE_SILENT = 3'd3,
      MODE_SLEEP  = 3'd4
   } lin_mode_e;
endpackage

// File: rtl/lin_sync.sv
// Multi-bit, multi-stage synchronizer for independent asynchronous flags.
module lin_sync #(
   parameter int          WIDTH   = 1,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lin_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("lin_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] pipe;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[s] <= RST_VAL;
               else        pipe[s] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[s] <= RST_VAL;
               else        pipe[s] <= pipe[s-1];
            end
         end
      end
   endgenerate

   assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/lin_mode_fsm.sv
// Mode state machine working on synchronized flags.
module lin_mode_fsm
   import lin_mode_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sup_s,
   input  logic      en_s,
   input  logic      txd_s,
   input  logic      uv_s,
   input  logic      wake_s,
   output lin_mode_e mode_o
);
   lin_mode_e mode_q, mode_d;
   logic      en_q;
   logic      en_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= en_s;
   end

   assign en_fall = en_q & ~en_s;

   always_comb begin
      mode_d = mode_q;
      if (!sup_s) begin
         mode_d = MODE_OFF;
      end else begin
         unique case (mode_q)
            MODE_OFF:    mode_d = MODE_SAFE;
            MODE_SAFE:   if (en_s && !uv_s) mode_d = MODE_NORMAL;
            MODE_NORMAL: begin
               if (uv_s)         mode_d = MODE_SAFE;
               else if (en_fall) mode_d = txd_s ? MODE_SILENT : MODE_SLEEP;
            end
            MODE_SILENT: begin
               if (uv_s)        mode_d = MODE_SAFE;
               else if (en_s)   mode_d = MODE_NORMAL;
               else if (wake_s) mode_d = MODE_SAFE;
            end
            MODE_SLEEP: begin
               if (en_s)        mode_d = MODE_NORMAL;
               else if (wake_s) mode_d = MODE_SAFE;
            end
            default:     mode_d = MODE_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_OFF;
      else        mode_q <= mode_d;
   end

   assign mode_o = mode_q;

   assert_powerup_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_OFF && sup_s) |=> (mode_q == MODE_SAFE));

   assert_silent_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_NORMAL && sup_s && !uv_s && en_fall && txd_s) |=> (mode_q == MODE_SILENT));

   assert_sleep_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_NORMAL && sup_s && !uv_s && en_fall && !txd_s) |=> (mode_q == MODE_SLEEP));

   assert_uv_fallback_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == MODE_NORMAL || mode_q == MODE_SILENT) && sup_s && uv_s) |=> (mode_q == MODE_SAFE));

   assert_supply_loss_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !sup_s |=> (mode_q == MODE_OFF));
endmodule

// File: rtl/lin_hold_timer.sv
// Reset hold-off: keeps reset low while held and for HOLD_TICKS after release.
module lin_hold_timer #(
   parameter int HOLD_TICKS = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_i,
   output logic res_n_o
);
   generate
      if (HOLD_TICKS < 0) begin : g_bad_hold
         $error("lin_hold_timer: HOLD_TICKS must not be negative");
      end

      if (HOLD_TICKS == 0) begin : g_no_timer
         assign res_n_o = ~hold_i;
      end else begin : g_timer
         localparam int CW = $clog2(HOLD_TICKS + 1);
         localparam logic [CW-1:0] LOAD = CW'(HOLD_TICKS);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= LOAD;
            else if (hold_i)         cnt_q <= LOAD;
            else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
         end

         assign res_n_o = (cnt_q == '0) && !hold_i;

         assert_hold_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
            hold_i |=> !res_n_o);
      end
   endgenerate
endmodule

// File: rtl/lin_mode_ctrl.sv
// Top: LIN transceiver operating-mode controller.
module lin_mode_ctrl
   import lin_mode_pkg::*;
#(
   parameter int TICKS_PER_MS = 8,
   parameter int HOLD_MS      = 4,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  logic       txd_i,
   input  logic       supply_ok_i,
   input  logic       vcc_uv_i,
   input  logic       wake_i,
   output logic [2:0] mode_o,
   output logic       reg_en_o,
   output logic       tx_en_o,
   output logic       term_en_o,
   output logic       res_n_o
);
   localparam int HOLD_TICKS = TICKS_PER_MS * HOLD_MS;
   localparam int N_IN       = 5;
   // Bit order: {wake, uv, supply, txd, en}; txd resets recessive.
   localparam logic [N_IN-1:0] SYNC_RST = 5'b00010;

   generate
      if (TICKS_PER_MS < 1) begin : g_bad_tick
         $error("lin_mode_ctrl: TICKS_PER_MS must be at least 1");
      end
   endgenerate

   logic [N_IN-1:0] raw, synced;
   lin_mode_e       mode;
   logic            hold;

   assign raw = {wake_i, vcc_uv_i, supply_ok_i, txd_i, en_i};

   lin_sync #(
      .WIDTH  (N_IN),
      .STAGES (SYNC_STAGES),
      .RST_VAL(SYNC_RST)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (raw),
      .q_o  (synced)
   );

   lin_mode_fsm u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .sup_s (synced[2]),
      .en_s  (synced[0]),
      .txd_s (synced[1]),
      .uv_s  (synced[3]),
      .wake_s(synced[4]),
      .mode_o(mode)
   );

   assign hold = synced[3] | (mode == MODE_OFF);

   lin_hold_timer #(
      .HOLD_TICKS(HOLD_TICKS)
   ) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold_i (hold),
      .res_n_o(res_n_o)
   );

   assign mode_o    = mode;
   assign reg_en_o  = (mode != MODE_SLEEP) && (mode != MODE_OFF);
   assign tx_en_o   = (mode == MODE_NORMAL);
   assign term_en_o = (mode == MODE_NORMAL) || (mode == MODE_SAFE);
endmodule

// File: tb/lin_mode_ctrl_bench.sv
module lin_mode_ctrl_bench;
   localparam int TPM  = 8;
   localparam int HMS  = 4;
   localparam int HOLD = TPM * HMS;

   localparam logic [2:0] M_OFF = 3'd0, M_SAFE = 3'd1, M_NORM = 3'd2,
                          M_SIL = 3'd3, M_SLP = 3'd4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, txd = 1'b1, sup = 1'b0, uv = 1'b0, wake = 1'b0;
   logic [2:0] mode;
   logic reg_en, tx_en, term_en, res_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   lin_mode_ctrl #(.TICKS_PER_MS(TPM), .HOLD_MS(HMS), .SYNC_STAGES(2)) u_lin_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .en_i(en), .txd_i(txd), .supply_ok_i(sup),
      .vcc_uv_i(uv), .wake_i(wake), .mode_o(mode), .reg_en_o(reg_en),
      .tx_en_o(tx_en), .term_en_o(term_en), .res_n_o(res_n)
   );

   function automatic logic [2:0] model_next(input logic [2:0] m, input logic s,
      input logic e, input logic f, input logic t, input logic u, input logic w);
      if (!s) return M_OFF;
      case (m)
         M_OFF:  return M_SAFE;
         M_SAFE: return (e && !u) ? M_NORM : M_SAFE;
         M_NORM: return u ? M_SAFE : (f ? (t ? M_SIL : M_SLP) : M_NORM);
         M_SIL:  return u ? M_SAFE : (e ? M_NORM : (w ? M_SAFE : M_SIL));
         M_SLP:  return e ? M_NORM : (w ? M_SAFE : M_SLP);
         default: return M_OFF;
      endcase
   endfunction

   function automatic logic [2:0] model_outs(input logic [2:0] m);
      // {reg_en, tx_en, term_en}
      return {(m != M_SLP && m != M_OFF), (m == M_NORM), (m == M_NORM || m == M_SAFE)};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_mode(input string req, input logic [2:0] m);
      check(req, {29'd0, mode}, {29'd0, m});
      check({req, "/R8"}, {29'd0, reg_en, tx_en, term_en}, {29'd0, model_outs(m)});
   endtask

   task automatic settle(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [2:0] m;
      logic       pen;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // reset state
      check_mode("R1 reset", M_OFF);
      check("R9 reset", {31'd0, res_n}, 32'd0);
      rst_n = 1'b1;
      settle(2);
      check_mode("R6 no supply", M_OFF);

      // R10 latency + R1 power-up with enable low
      sup = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      check("R10 before third edge", {29'd0, mode}, {29'd0, M_OFF});
      @(posedge clk); @(negedge clk);
      check_mode("R10 R1 power-up to fail-safe", M_SAFE);
      settle(4);
      check_mode("R1 enable low stays fail-safe", M_SAFE);

      // R2
      en = 1'b1;
      settle(4);
      check_mode("R2 fail-safe to normal", M_NORM);

      // R3
      txd = 1'b1; en = 1'b0;
      settle(4);
      check_mode("R3 silent entry", M_SIL);

      // R7 wake from silent
      wake = 1'b1; settle(4); wake = 1'b0; settle(3);
      check_mode("R7 silent wake", M_SAFE);

      // R2 and R4
      en = 1'b1; settle(4);
      check_mode("R2 back to normal", M_NORM);
      txd = 1'b0; settle(3);
      en = 1'b0; settle(4);
      check_mode("R4 sleep entry", M_SLP);

      // R5 undervoltage ignored in sleep
      uv = 1'b1; settle(5);
      check_mode("R5 uv in sleep ignored", M_SLP);
      check("R9 uv holds reset", {31'd0, res_n}, 32'd0);
      uv = 1'b0; settle(HOLD + 4);

      // R7 wake from sleep
      wake = 1'b1; settle(4); wake = 1'b0; settle(3);
      check_mode("R7 sleep wake", M_SAFE);

      // R2 blocked by undervoltage in fail-safe
      uv = 1'b1; en = 1'b1; settle(5);
      check_mode("R2 uv blocks normal", M_SAFE);
      uv = 1'b0; settle(HOLD + 4);
      check_mode("R2 normal after uv", M_NORM);
      check("R9 reset released", {31'd0, res_n}, 32'd1);

      // R5 uv in normal + R9 exact hold length
      uv = 1'b1; settle(4);
      check_mode("R5 uv normal fallback", M_SAFE);
      check("R9 reset low on uv", {31'd0, res_n}, 32'd0);
      uv = 1'b0;
      repeat (HOLD + 1) @(posedge clk);
      @(negedge clk);
      check("R9 still low at end of hold", {31'd0, res_n}, 32'd0);
      @(posedge clk); @(negedge clk);
      check("R9 high after hold", {31'd0, res_n}, 32'd1);

      // R5 uv in silent
      txd = 1'b1; en = 1'b0; settle(4);
      check_mode("R3 silent again", M_SIL);
      uv = 1'b1; settle(4);
      check_mode("R5 uv silent fallback", M_SAFE);
      uv = 1'b0; settle(HOLD + 4);

      // R6 supply loss from fail-safe
      sup = 1'b0; settle(4);
      check_mode("R6 supply loss", M_OFF);
      check("R9 reset low unpowered", {31'd0, res_n}, 32'd0);

      // random phase
      m = M_OFF; pen = en;
      for (int i = 0; i < 400; i++) begin
         logic f;
         sup  = ($urandom % 10) != 0;
         en   = $urandom % 2;
         txd  = $urandom % 2;
         uv   = ($urandom % 7) == 0;
         wake = ($urandom % 6) == 0;
         f = pen & ~en;
         for (int k = 0; k < 5; k++) begin
            m = model_next(m, sup, en, (k == 0) ? f : 1'b0, txd, uv, wake);
         end
         pen = en;
         settle(8);
         check_mode("R10 random mode R2 R3 R4 R5 R6 R7", m);
         if (uv || m == M_OFF) check("R9 random reset", {31'd0, res_n}, 32'd0);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule